// File: doc/BRIEF.md
# Corner-Turn Serial Output Former

This block takes a time-compressed, already switched stream of 8-bit slot words and turns it into eight serial output group channels, one bit per channel per bit period. Each incoming word is stored whole into one column of a bit matrix. The read side walks the matrix one row position at a time, so every bit period yields one bit for each of the eight lanes. The result is a parallel-to-eight-serial transpose.

Two matrices form a ping-pong pair. During a frame one bank collects the words while the other is played out. A frame sync pulse swaps the two banks and restarts both pointers, which keeps the output continuous. Three single-cycle strobes from an external timing generator pace the block: `frame_sync` marks the frame boundary, `wr_strobe` marks each slot word, and `bit_tick` marks each output bit period.

The control is a three-state machine. `ST_WAIT` is the reset state, in which writes are ignored. Transition T_ARM (on `frame_sync`) goes from `ST_WAIT` to `ST_FILL`, in which the first frame is collected while the outputs stay at 0. Transition T_PRIME (on `frame_sync`) goes from `ST_FILL` to `ST_STREAM`, in which the outputs play the previous frame. Transition T_SWAP (on `frame_sync`) goes from `ST_STREAM` back to `ST_STREAM` and exchanges the banks. In all other cases each state stays where it is.

Top module: `ct_stream_former`

## Requirements
- R1: After reset `ser_out` is all zeros and the machine is in the waiting state.
- R2: `ser_out` stays all zeros until the second `frame_sync` after reset. This covers the waiting state and the whole first (fill) frame, whatever `bit_tick` does.
- R3: The n-th accepted word after a `frame_sync` (n = 0..255, counting from 0) is stored for slot n>>3 and output lane n&7. The low 3 bits of the write address select the lane and the upper 5 bits select the slot.
- R4: Bits go out MSB first. In bit period b (0..7) of slot s, lane k carries bit 7-b of the word stored for (s, k).
- R5: During any frame in the streaming state, the lanes play exactly the words written during the preceding frame (ping-pong).
- R6: Once 256 words have been accepted in a frame, further `wr_strobe` pulses in that frame are ignored and the stored words are unchanged.
- R7: The read position advances by one bit period per `bit_tick`. After slot 31 bit 7 it wraps to slot 0 bit 0 of the same bank.
- R8: A `frame_sync` ends the frame at any point. The read position returns to slot 0 bit 0 of the other bank and the next word goes to write address 0. Cells of the new write bank that are not rewritten keep the contents they held two frames before.
- R9: `ser_out` is registered. A change of read position caused by `frame_sync` or `bit_tick` at one clock edge appears on `ser_out` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame boundary strobe; swaps banks, restarts pointers |
| wr_strobe | input | 1 | Slot word valid strobe |
| wr_word | input | 8 | Switched slot word |
| bit_tick | input | 1 | Output bit period strobe |
| ser_out | output | 8 | One serial bit per output lane |

## Verification
The in-line assertions check, on every cycle, that the outputs stay silent outside streaming, that each frame sync swaps the banks and zeroes both pointers, that the read pointer wraps at the frame end, and that a full write pointer stays frozen. Only the bench scenarios can show the data path itself. These scenarios cover the lane and slot placement of words, MSB-first serialisation, the one-frame delay through the ping-pong pair, overflow words that leave the stored content untouched, and cells left over from two frames earlier after a short frame.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } ct_state_e;
endpackage

// File: rtl/ct_seq.sv
module ct_seq
    import ct_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int LANES  = 8,
    parameter int WORD_W = 8,
    localparam int AW = $clog2(SLOTS * LANES),
    localparam int PW = $clog2(SLOTS * WORD_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    input  logic          wr_strobe,
    input  logic          bit_tick,
    output ct_state_e     state,
    output logic          wr_en,
    output logic [AW-1:0] wr_sel_addr,
    output logic          wr_sel_bank,
    output logic [PW-1:0] rd_ptr,
    output logic          rd_bank
);
    localparam logic [AW-1:0] ADDR_LAST = AW'(SLOTS * LANES - 1);
    localparam logic [PW-1:0] PTR_LAST  = PW'(SLOTS * WORD_W - 1);

    ct_state_e     state_nx;
    logic [AW-1:0] wr_addr;
    logic          wr_full;
    logic          wr_bank;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // transitions T_ARM, T_PRIME, T_SWAP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:   if (frame_sync) state_nx = ST_FILL;
            ST_FILL:   if (frame_sync) state_nx = ST_STREAM;
            ST_STREAM: state_nx = ST_STREAM;
            default:   state_nx = ST_WAIT;
        endcase
    end

    // write port selection
    always_comb begin
        wr_sel_addr = frame_sync ? '0 : wr_addr;
        wr_sel_bank = frame_sync ? ~wr_bank : wr_bank;
        wr_en       = 1'b0;
        unique case (state)
            ST_WAIT:   wr_en = wr_strobe && frame_sync;
            ST_FILL,
            ST_STREAM: wr_en = wr_strobe && (frame_sync || !wr_full);
            default:   wr_en = 1'b0;
        endcase
    end

    assign rd_bank = ~wr_bank;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_full <= 1'b0;
            wr_bank <= 1'b0;
            rd_ptr  <= '0;
        end else begin
            if (frame_sync) begin
                wr_bank <= ~wr_bank;
                rd_ptr  <= '0;
            end else if (bit_tick) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (frame_sync && !wr_en) begin
                wr_addr <= '0;
                wr_full <= 1'b0;
            end else if (wr_en) begin
                wr_addr <= wr_sel_addr + 1'b1;
                wr_full <= (wr_sel_addr == ADDR_LAST);
            end
        end
    end

    // R8
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (rd_ptr == '0) && (rd_bank != $past(rd_bank)))
        else $error("frame sync did not restart read side");

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !frame_sync && rd_ptr == PTR_LAST) |=> (rd_ptr == '0))
        else $error("read pointer did not wrap");

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && !frame_sync) |=> (wr_full && $stable(wr_addr)))
        else $error("write pointer moved past a full frame");

    // R2
    stream_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> (state != ST_STREAM))
        else $error("streaming entered without a fill frame");
endmodule

// File: rtl/ct_bank.sv
module ct_bank #(
    parameter int SLOTS  = 32,
    parameter int LANES  = 8,
    parameter int WORD_W = 8,
    localparam int AW = $clog2(SLOTS * LANES),
    localparam int SW = $clog2(SLOTS),
    localparam int LW = $clog2(LANES),
    localparam int BW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [SW-1:0]     rslot,
    input  logic [BW-1:0]     rbit,
    output logic [LANES-1:0]  rlanes
);
    logic [WORD_W-1:0] cells [SLOTS*LANES];
    logic [BW-1:0]     bidx;

    // column write: whole word into one cell
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // row read: MSB first within the slot
    assign bidx = BW'(WORD_W - 1) - rbit;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [AW-1:0] col;
        assign col       = {rslot, LW'(k)};
        assign rlanes[k] = cells[col][bidx];
    end
endmodule

// File: rtl/ct_stream_former.sv
module ct_stream_former
    import ct_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int LANES  = 8,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              wr_strobe,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              bit_tick,
    output logic [LANES-1:0]  ser_out
);
    localparam int AW = $clog2(SLOTS * LANES);
    localparam int PW = $clog2(SLOTS * WORD_W);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = $clog2(WORD_W);

    ct_state_e      state;
    logic           wr_en;
    logic [AW-1:0]  wr_sel_addr;
    logic           wr_sel_bank;
    logic [PW-1:0]  rd_ptr;
    logic           rd_bank;
    logic [LANES-1:0] bank_lanes [2];
    logic [LANES-1:0] lanes_sel;

    ct_seq #(.SLOTS(SLOTS), .LANES(LANES), .WORD_W(WORD_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .wr_strobe   (wr_strobe),
        .bit_tick    (bit_tick),
        .state       (state),
        .wr_en       (wr_en),
        .wr_sel_addr (wr_sel_addr),
        .wr_sel_bank (wr_sel_bank),
        .rd_ptr      (rd_ptr),
        .rd_bank     (rd_bank)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        ct_bank #(.SLOTS(SLOTS), .LANES(LANES), .WORD_W(WORD_W)) bank_i (
            .clk    (clk),
            .we     (wr_en && (wr_sel_bank == 1'(g))),
            .waddr  (wr_sel_addr),
            .wdata  (wr_word),
            .rslot  (rd_ptr[PW-1:BW]),
            .rbit   (rd_ptr[BW-1:0]),
            .rlanes (bank_lanes[g])
        );
    end

    assign lanes_sel = bank_lanes[rd_bank];

    // output register, silent unless streaming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= '0;
        end else begin
            unique case (state)
                ST_STREAM:       ser_out <= lanes_sel;
                ST_WAIT, ST_FILL: ser_out <= '0;
                default:         ser_out <= '0;
            endcase
        end
    end

    // R2
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STREAM) |=> (ser_out == '0))
        else $error("output active outside streaming");

    // R5
    bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !frame_sync |-> (wr_sel_bank != rd_bank))
        else $error("write hit the bank being read");
endmodule

// File: tb/ct_stream_former_tb_top.sv
module ct_stream_former_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_word = '0;
    logic       bit_tick = 1'b0;
    logic [7:0] ser_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] got [256];

    always #5 clk = ~clk;

    ct_stream_former dut_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .wr_strobe(wr_strobe),
        .wr_word(wr_word), .bit_tick(bit_tick), .ser_out(ser_out)
    );

    function automatic logic [7:0] pat(input int f, input int a);
        return 8'((a * 29 + f * 101 + 7) ^ (a >> 2));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic sync_pulse();
        frame_sync = 1'b1; @(negedge clk); frame_sync = 1'b0; @(negedge clk);
    endtask

    task automatic tick();
        bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_strobe = 1'b1; wr_word = d; @(negedge clk); wr_strobe = 1'b0;
    endtask

    // gathers n slots of bits starting at the current position into got[]
    task automatic gather(input int nslots);
        for (int s = 0; s < nslots; s++)
            for (int b = 0; b < 8; b++) begin
                for (int k = 0; k < 8; k++) got[s*8+k][7-b] = ser_out[k];
                if (!(s == nslots - 1 && b == 7)) tick();
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset output", ser_out, 8'h00);

        // writes and ticks before any sync
        for (int i = 0; i < 5; i++) wr(8'hFF);
        tick();
        chk("R2 waiting output", ser_out, 8'h00);

        // fill frame: data of frame 0
        sync_pulse();
        for (int a = 0; a < 256; a++) wr(pat(0, a));
        for (int i = 0; i < 16; i++) begin
            chk("R2 fill output", ser_out, 8'h00);
            tick();
        end

        // stream frame 0 while writing frame 1 plus overflow words
        sync_pulse();
        for (int a = 0; a < 256; a++) wr(pat(1, a));
        for (int i = 0; i < 4; i++) wr(~pat(1, i));
        gather(32);
        for (int a = 0; a < 256; a++)
            chk("R3 R4 R5 R9 frame 0 replay", got[a], pat(0, a));

        // stream frame 1, check overflow rejected, then wrap
        sync_pulse();
        gather(32);
        for (int a = 0; a < 256; a++)
            chk("R5 R6 frame 1 replay", got[a], pat(1, a));
        tick();
        gather(1);
        for (int a = 0; a < 8; a++)
            chk("R7 wrap to slot 0", got[a], pat(1, a));

        // short frame 2: only 20 words, then early sync mid-read
        for (int a = 0; a < 20; a++) wr(pat(2, a));
        tick(); tick(); tick();
        sync_pulse();
        gather(32);
        for (int a = 0; a < 256; a++)
            chk("R8 short frame restart", got[a], (a < 20) ? pat(2, a) : pat(0, a));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule